// File: doc/BRIEF.md
# Table-Driven Multiway Sequencer

This block is a sixteen-state synchronous sequencer whose every transition comes from a next-state table that is fixed when the block is elaborated. Each state owns two stored successors. On each clock the lowest control bit chooses one of them, which gives a two-way branch from any state. A state that stores itself as a successor makes a hold loop. A state that stores the same successor twice never branches.

Selected states are flagged as eight-way branch points. When the sequencer enters a flagged state, an extra activation bit is registered together with the new state. On the next transition that bit steers a multiplexer. The lowest control bit still picks one of the two stored successors, but only that successor's upper two bits are kept, and they name one of the quadrants 0-3, 4-7, 8-11 or 12-15. The two upper control bits supply the position inside that quadrant. The result is eight possible destinations in up to two quadrants.

Eight decoded outputs follow the registered state. Each output is the OR of a programmable set of states. All control inputs must already be synchronous to the clock.

Top module: `branch_seq`

## Requirements
- R1: While `rst` is high on a rising edge, the state becomes 0 and the branch-activation bit is cleared. The first transition after reset is therefore a two-way branch, even if the controls would select a different target under an eight-way branch.
- R2: From a state that is not an eight-way point, the next state is successor A when `ctrl_i[0]` is 0 and successor B when `ctrl_i[0]` is 1. Successor s is held at bits `[4s+3:4s]` of the table parameter.
- R3: A state whose selected successor equals itself stays in that state on the clock edge.
- R4: When a state's two successors are equal, the value of `ctrl_i[0]` has no effect on the next state.
- R5: From an eight-way state, the next state is `{sel[3:2], ctrl_i[2:1]}`, where `sel` is the successor chosen by `ctrl_i[0]`. Eight different control values reach eight destinations.
- R6: `ctrl_i[2:1]` has no effect on a transition out of a state that is not an eight-way point.
- R7: The activation bit is set only by entering a flagged state. The transition that follows an eight-way branch into an unflagged state is an ordinary two-way branch.
- R8: `dec_o[k]` is 1 exactly when bit `16k + state` of the decode parameter is set. It is valid in the same cycle as `state_o` and changes only when the state changes.
- R9: The state is registered. A change on `ctrl_i` does not move `state_o` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 3 | Control inputs: bit 0 picks the successor, bits 2:1 pick the position inside the quadrant |
| state_o | output | 4 | Current state |
| dec_o | output | 8 | Decoded outputs, each the OR of a programmable set of states |

## Verification
On every cycle, the bound checker verifies the reset value, the two-way choice, the hold loop, the eight-way substitution and the rule that the outputs only move with the state. It does this by comparing each new state with the successor the table gave one cycle earlier. Some behaviour only the bench's scenarios can show, because it depends on the order of events across several cycles. This includes the eight distinct destinations from one branch point, a reset that arrives while the activation bit is set, and the ordinary branch that follows an eight-way jump. A long random walk across the whole bench table then checks every step against an arithmetic model.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

   // Kind of transition taken out of the current state
   typedef enum logic {
      BR_TWO_WAY   = 1'b0,
      BR_EIGHT_WAY = 1'b1
   } br_kind_e;

   localparam int unsigned DEF_STATE_W = 4;
   localparam int unsigned DEF_SUB_W   = 2;
   localparam int unsigned DEF_N_OUT   = 8;

endpackage

// File: rtl/branch_seq_next.sv
module branch_seq_next
   import branch_seq_pkg::*;
#(
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned SUB_W    = 2,
   parameter int unsigned N_STATES = 1 << STATE_W,
   parameter logic [N_STATES*STATE_W-1:0] NS_A = '0,
   parameter logic [N_STATES*STATE_W-1:0] NS_B = '0,
   parameter logic [N_STATES-1:0]         MW_MASK = '0
) (
   input  logic [STATE_W-1:0] state_q,
   input  logic               arm_q,
   input  logic [SUB_W:0]     ctrl,
   output logic [STATE_W-1:0] next_state,
   output logic               next_arm
);

   localparam int unsigned HI_W = STATE_W - SUB_W;

   logic [STATE_W-1:0] tab_a [N_STATES];
   logic [STATE_W-1:0] tab_b [N_STATES];
   logic [STATE_W-1:0] pick;
   logic [HI_W-1:0]    quad;
   br_kind_e           kind;

   for (genvar i = 0; i < N_STATES; i++) begin : g_tab
      assign tab_a[i] = NS_A[i*STATE_W +: STATE_W];
      assign tab_b[i] = NS_B[i*STATE_W +: STATE_W];
   end

   assign pick = ctrl[0] ? tab_b[state_q] : tab_a[state_q];
   assign quad = pick[STATE_W-1:SUB_W];
   assign kind = arm_q ? BR_EIGHT_WAY : BR_TWO_WAY;

   always_comb begin
      case (kind)
         BR_EIGHT_WAY: next_state = {quad, ctrl[SUB_W:1]};
         default:      next_state = pick;
      endcase
   end

   // Activation bit is loaded together with the state it belongs to
   assign next_arm = MW_MASK[next_state];

endmodule

// File: rtl/branch_seq_reg.sv
module branch_seq_reg #(
   parameter int unsigned STATE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] next_state,
   input  logic               next_arm,
   output logic [STATE_W-1:0] state_q,
   output logic               arm_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= '0;
         arm_q   <= 1'b0;
      end else begin
         state_q <= next_state;
         arm_q   <= next_arm;
      end
   end

endmodule

// File: rtl/branch_seq_decode.sv
module branch_seq_decode #(
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned N_STATES = 1 << STATE_W,
   parameter int unsigned N_OUT    = 8,
   parameter logic [N_OUT*N_STATES-1:0] DEC_MASK = '0
) (
   input  logic [STATE_W-1:0] state_q,
   output logic [N_OUT-1:0]   dec
);

   logic [N_STATES-1:0] onehot;

   assign onehot = {{(N_STATES-1){1'b0}}, 1'b1} << state_q;

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      assign dec[k] = |(onehot & DEC_MASK[k*N_STATES +: N_STATES]);
   end

endmodule

// File: rtl/branch_seq.sv
module branch_seq
   import branch_seq_pkg::*;
#(
   parameter int unsigned STATE_W = DEF_STATE_W,
   parameter int unsigned SUB_W   = DEF_SUB_W,
   parameter int unsigned N_OUT   = DEF_N_OUT,
   parameter logic [(1<<STATE_W)*STATE_W-1:0] NS_A    = 64'h0FED_CBA9_8765_4321,
   parameter logic [(1<<STATE_W)*STATE_W-1:0] NS_B    = 64'hFEDC_BA98_7654_3210,
   parameter logic [(1<<STATE_W)-1:0]         MW_MASK = 16'h0100,
   parameter logic [N_OUT*(1<<STATE_W)-1:0]   DEC_MASK =
      128'hC000_3000_0C00_0300_00C0_0030_000C_0003
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [SUB_W:0]     ctrl_i,
   output logic [STATE_W-1:0] state_o,
   output logic [N_OUT-1:0]   dec_o
);

   localparam int unsigned N_STATES = 1 << STATE_W;

   if (SUB_W < 1 || SUB_W >= STATE_W) begin : g_bad_sub
      $error("branch_seq: SUB_W must lie in 1..STATE_W-1");
   end
   if (N_OUT < 1) begin : g_bad_out
      $error("branch_seq: N_OUT must be at least 1");
   end

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] next_state;
   logic               arm_q;
   logic               next_arm;

   branch_seq_next #(
      .STATE_W (STATE_W),
      .SUB_W   (SUB_W),
      .N_STATES(N_STATES),
      .NS_A    (NS_A),
      .NS_B    (NS_B),
      .MW_MASK (MW_MASK)
   ) i_next (
      .state_q   (state_q),
      .arm_q     (arm_q),
      .ctrl      (ctrl_i),
      .next_state(next_state),
      .next_arm  (next_arm)
   );

   branch_seq_reg #(
      .STATE_W(STATE_W)
   ) i_reg (
      .clk       (clk),
      .rst       (rst),
      .next_state(next_state),
      .next_arm  (next_arm),
      .state_q   (state_q),
      .arm_q     (arm_q)
   );

   branch_seq_decode #(
      .STATE_W (STATE_W),
      .N_STATES(N_STATES),
      .N_OUT   (N_OUT),
      .DEC_MASK(DEC_MASK)
   ) i_dec (
      .state_q(state_q),
      .dec    (dec_o)
   );

   assign state_o = state_q;

endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
   parameter int unsigned STATE_W = 4,
   parameter int unsigned SUB_W   = 2,
   parameter int unsigned N_OUT   = 8,
   parameter logic [(1<<STATE_W)*STATE_W-1:0] NS_A    = '0,
   parameter logic [(1<<STATE_W)*STATE_W-1:0] NS_B    = '0,
   parameter logic [(1<<STATE_W)-1:0]         MW_MASK = '0
) (
   input logic               clk,
   input logic               rst,
   input logic [SUB_W:0]     ctrl_i,
   input logic [STATE_W-1:0] state_o,
   input logic [N_OUT-1:0]   dec_o
);

   localparam int unsigned N_STATES = 1 << STATE_W;

   logic [STATE_W-1:0]       ta [N_STATES];
   logic [STATE_W-1:0]       tb [N_STATES];
   logic [STATE_W-1:0]       cur_pick;
   logic [STATE_W-SUB_W-1:0] cur_hi;
   logic                     cur_mw;

   for (genvar i = 0; i < N_STATES; i++) begin : g_tab
      assign ta[i] = NS_A[i*STATE_W +: STATE_W];
      assign tb[i] = NS_B[i*STATE_W +: STATE_W];
   end

   assign cur_pick = ctrl_i[0] ? tb[state_o] : ta[state_o];
   assign cur_hi   = cur_pick[STATE_W-1:SUB_W];
   assign cur_mw   = MW_MASK[state_o];

   // R1: state is 0 after a reset edge
   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> state_o == '0);

   // R1: first transition after reset is two-way (activation cleared)
   p_reset_arm_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst, 2) && !$past(rst)) |-> state_o == $past(cur_pick));

   // R2: ordinary two-way branch
   p_two_way_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && !$past(cur_mw))
      |-> state_o == $past(cur_pick));

   // R3: hold loop keeps the state
   p_hold_loop_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && !$past(cur_mw)
       && $past(cur_pick) == $past(state_o)) |-> $stable(state_o));

   // R5: eight-way substitution of the low bits
   p_eight_way_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(cur_mw))
      |-> state_o == {$past(cur_hi), $past(ctrl_i[SUB_W:1])});

   // R8: decoded outputs only move with the state
   p_dec_follows_r8: assert property (@(posedge clk) disable iff (rst)
      $stable(state_o) |-> $stable(dec_o));

endmodule

bind branch_seq branch_seq_chk #(
   .STATE_W(STATE_W),
   .SUB_W  (SUB_W),
   .N_OUT  (N_OUT),
   .NS_A   (NS_A),
   .NS_B   (NS_B),
   .MW_MASK(MW_MASK)
) i_chk (
   .clk    (clk),
   .rst    (rst),
   .ctrl_i (ctrl_i),
   .state_o(state_o),
   .dec_o  (dec_o)
);

// File: tb/test_branch_seq.sv
module test_branch_seq;

   function automatic logic [3:0] f_a(int s);
      if (s == 5) return 4'd5;
      if (s == 9) return 4'd12;
      return 4'((s + 1) % 16);
   endfunction

   function automatic logic [3:0] f_b(int s);
      if (s == 9)  return 4'd12;
      if (s == 13) return 4'd2;
      return 4'((7 * s + 3) % 16);
   endfunction

   function automatic logic f_mw(int s);
      return (s == 6) || (s == 13);
   endfunction

   function automatic logic [7:0] dec_vec(int s);
      logic [7:0] v;
      for (int k = 0; k < 8; k++) v[k] = ((s % (k + 2)) == 0);
      return v;
   endfunction

   function automatic logic [63:0] mk_a();
      logic [63:0] v;
      for (int s = 0; s < 16; s++) v[s*4 +: 4] = f_a(s);
      return v;
   endfunction

   function automatic logic [63:0] mk_b();
      logic [63:0] v;
      for (int s = 0; s < 16; s++) v[s*4 +: 4] = f_b(s);
      return v;
   endfunction

   function automatic logic [15:0] mk_mw();
      logic [15:0] v;
      for (int s = 0; s < 16; s++) v[s] = f_mw(s);
      return v;
   endfunction

   function automatic logic [127:0] mk_dec();
      logic [127:0] v;
      for (int k = 0; k < 8; k++)
         for (int s = 0; s < 16; s++) v[k*16 + s] = ((s % (k + 2)) == 0);
      return v;
   endfunction

   localparam logic [63:0]  TB_A   = mk_a();
   localparam logic [63:0]  TB_B   = mk_b();
   localparam logic [15:0]  TB_MW  = mk_mw();
   localparam logic [127:0] TB_DEC = mk_dec();

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] ctrl_i = 3'b000;
   logic [3:0] state_o;
   logic [7:0] dec_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [3:0] exp_state = 4'd0;
   logic       exp_arm   = 1'b0;

   always #2 clk = ~clk;

   branch_seq #(
      .STATE_W (4),
      .SUB_W   (2),
      .N_OUT   (8),
      .NS_A    (TB_A),
      .NS_B    (TB_B),
      .MW_MASK (TB_MW),
      .DEC_MASK(TB_DEC)
   ) i_branch_seq (
      .clk    (clk),
      .rst    (rst),
      .ctrl_i (ctrl_i),
      .state_o(state_o),
      .dec_o  (dec_o)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Reset held across two rising edges; entered and left at a falling edge
   task automatic do_reset(input logic [2:0] c);
      rst    = 1'b1;
      ctrl_i = c;
      @(negedge clk);
      @(negedge clk);
      check(state_o == 4'd0, "R1 state in reset", state_o, 0);
      rst       = 1'b0;
      exp_state = 4'd0;
      exp_arm   = 1'b0;
      check(dec_o == dec_vec(0), "R8 decode in reset", dec_o, dec_vec(0));
   endtask

   // One transition; called at a falling edge, returns at the next falling edge
   task automatic step(input logic [2:0] c, input string tag);
      logic [3:0] pick;
      logic [3:0] nxt;
      ctrl_i = c;
      pick = c[0] ? f_b(exp_state) : f_a(exp_state);
      nxt  = exp_arm ? {pick[3:2], c[2:1]} : pick;
      #1;
      check(state_o == exp_state, "R9 no move before edge", state_o, exp_state);
      @(posedge clk);
      @(negedge clk);
      check(state_o == nxt, tag, state_o, nxt);
      check(dec_o == dec_vec(nxt), "R8 decode", dec_o, dec_vec(nxt));
      exp_state = nxt;
      exp_arm   = f_mw(nxt);
   endtask

   task automatic goto6();
      for (int i = 0; i < 5; i++) step(3'b000, "R2 walk A");
      step(3'b001, "R2 take B into 6");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset(3'b000);

      // R6: upper controls ignored on an ordinary branch (0 -> A[0] = 1)
      step(3'b110, "R6 upper bits ignored");
      do_reset(3'b011);
      step(3'b000, "R2 successor A from 0");
      do_reset(3'b000);
      step(3'b001, "R2 successor B from 0");

      // R3: state 5 holds on successor A
      do_reset(3'b000);
      for (int i = 0; i < 5; i++) step(3'b000, "R2 walk A");
      step(3'b000, "R3 hold loop");
      step(3'b110, "R3 hold loop again");

      // R5: all eight destinations from branch point 6
      for (int c = 0; c < 8; c++) begin
         do_reset(3'b000);
         goto6();
         step(3'(c), "R5 eight-way destination");
      end

      // R7: after an eight-way jump to 14, an ordinary branch follows (A[14] = 15, not 13)
      do_reset(3'b000);
      goto6();
      step(3'b101, "R5 jump to 14");
      step(3'b010, "R7 ordinary after eight-way");

      // R1: reset while activation set; next branch must be two-way (expect 1, not 3)
      do_reset(3'b000);
      goto6();
      do_reset(3'b110);
      step(3'b110, "R1 activation cleared by reset");

      // R4: state 9 has equal successors (12) for both control values
      for (int c = 0; c < 2; c++) begin
         do_reset(3'b000);
         goto6();
         step(3'b110, "R5 jump to 7");
         step(3'b000, "R2 7 to 8");
         step(3'b000, "R2 8 to 9");
         step(3'(c), "R4 equal successors");
      end

      // Random walk over the whole table, tagged by situation
      do_reset(3'b000);
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] c;
         logic [3:0] pk;
         c  = 3'($urandom_range(0, 7));
         pk = c[0] ? f_b(exp_state) : f_a(exp_state);
         if (exp_arm)                              step(c, "R5 random eight-way");
         else if (f_a(exp_state) == f_b(exp_state)) step(c, "R4 random equal");
         else if (pk == exp_state)                 step(c, "R3 random hold");
         else                                      step(c, "R2 random two-way");
      end

      finish_run();
   end

endmodule